// File: doc/BRIEF.md
# Receive FIFO with Threshold Interrupts

This block sits between a serial receiver and the CPU. It stores received characters in an eight-entry first-in first-out buffer. Each entry holds a data byte and an error mark. The receiver pushes bytes through a write strobe. The CPU pops them through a read strobe, and the popped byte appears on a registered output port one cycle after the strobe.

A write-only control register sets when the receive-available interrupt fires. It can fire as soon as one byte is stored, or only once half the buffer (four bytes) is filled. With the half-full setting, software can take several bytes per interrupt. A second control bit enables special-condition interrupts. In half-full mode, a character carrying an error mark then raises its own interrupt as soon as it sits among the four oldest stored entries. This happens even when fewer than four bytes are held.

A status output shows that at least one character is waiting, so a handler can keep draining after an interrupt. Writes to a full buffer are lost and latch a sticky overrun flag until a clear strobe.

Top module: `rx_thresh_fifo`

## Requirements
- R1: After reset the fill level is 0, all interrupt, status and overrun outputs are 0, `rd_data`/`rd_flag` are 0, and the one-byte threshold with special interrupts off is in force.
- R2: With control bit 3 at 0, `irq_rx_avail` is 1 exactly when the fill level is at least 1.
- R3: With control bit 3 at 1, `irq_rx_avail` is 1 exactly when the fill level is at least 4.
- R4: Entries leave in arrival order with their flag. A read with data present loads `rd_data`/`rd_flag` at the next clock edge. The fill level never exceeds 8.
- R5: `irq_special` is 1 exactly when control bit 3 and control bit 0 are both 1 and one of the (up to) four oldest stored entries carries a set flag. It drops once that entry is read out.
- R6: `char_avail` is 1 exactly when the fill level is non-zero.
- R7: A write to a full buffer without a read in the same cycle is discarded and sets `overrun`. `overrun` stays set until `err_clr` is pulsed, and a new discard in the same cycle as `err_clr` wins.
- R8: A read while empty leaves `rd_data`, `rd_flag` and the fill level unchanged.
- R9: A read and a write in the same cycle with data present leave the fill level unchanged and keep order; this includes a full buffer.
- R10: A control write takes effect at the next clock edge. Only bits 3 and 0 are stored, and all other bits of `cfg_wdata` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control value; bit 3 half-full threshold, bit 0 special enable |
| wr_en | input | 1 | Receiver push strobe |
| wr_data | input | DATA_W | Received byte |
| wr_flag | input | 1 | Error mark of the received byte |
| rd_en | input | 1 | CPU pop strobe |
| rd_data | output | DATA_W | Last popped byte |
| rd_flag | output | 1 | Error mark of the last popped byte |
| err_clr | input | 1 | Clears the overrun flag |
| fill_level | output | CNT_W | Number of stored entries |
| char_avail | output | 1 | At least one entry stored |
| irq_rx_avail | output | 1 | Receive-available interrupt |
| irq_special | output | 1 | Special-condition interrupt |
| overrun | output | 1 | Sticky lost-write flag |

## Verification
The assertions take for granted that every strobe is a clean synchronous level, sampled once per edge. They also assume that a write on a full buffer is meaningful only when paired or unpaired with a read exactly as seen at that edge. The stimulus changes inputs only on the falling edge. It mixes directed fills past the full point, reads on an empty buffer, same-cycle push and pop on both empty and full buffers, and control rewrites with the unused bits set. A long random stretch toggles the threshold and enable bits while flagged bytes pass through the four oldest positions.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int CFG_W        = 8;
    localparam int CFG_HALF_BIT = 3;
    localparam int CFG_SC_BIT   = 0;

    typedef struct packed {
        logic half;
        logic sc_en;
        logic ovr;
    } rxf_ctl_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int HALF   = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_flag,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_flag,
    output logic [CNT_W-1:0]  count,
    output logic [HALF-1:0]   win_flag,
    output logic              drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] dat;
        logic [DEPTH-1:0]             flg;
        logic [PTR_W-1:0]             rp;
        logic [PTR_W-1:0]             wp;
        logic [CNT_W-1:0]             cnt;
        logic [DATA_W-1:0]            rdat;
        logic                         rflg;
    } st_t;

    st_t s_d, s_q;
    logic pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        pop_ok  = pop_req && (s_q.cnt != '0);
        push_ok = push_req && ((s_q.cnt != CNT_W'(DEPTH)) || pop_ok);
        drop    = push_req && !push_ok;
        if (pop_ok) begin
            s_d.rdat = s_q.dat[s_q.rp];
            s_d.rflg = s_q.flg[s_q.rp];
            s_d.rp   = ptr_inc(s_q.rp);
        end
        if (push_ok) begin
            s_d.dat[s_q.wp] = push_data;
            s_d.flg[s_q.wp] = push_flag;
            s_d.wp          = ptr_inc(s_q.wp);
        end
        case ({push_ok, pop_ok})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // flags of the oldest HALF entries, masked by occupancy
    for (genvar i = 0; i < HALF; i++) begin : g_win
        logic [PTR_W:0] sum;
        logic [PTR_W-1:0] idx;
        always_comb begin
            sum = {1'b0, s_q.rp} + (PTR_W+1)'(i);
            idx = (sum >= (PTR_W+1)'(DEPTH)) ? PTR_W'(sum - (PTR_W+1)'(DEPTH)) : sum[PTR_W-1:0];
            win_flag[i] = s_q.flg[idx] && (s_q.cnt > CNT_W'(i));
        end
    end

    assign pop_data = s_q.rdat;
    assign pop_flag = s_q.rflg;
    assign count    = s_q.cnt;
endmodule

// File: rtl/rxf_irq.sv
module rxf_irq #(
    parameter int HALF  = 4,
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] count,
    input  logic [HALF-1:0]  win_flag,
    input  logic             half,
    input  logic             sc_en,
    output logic             irq_rx,
    output logic             irq_sc
);
    logic [CNT_W-1:0] thresh;

    always_comb begin
        thresh = half ? CNT_W'(HALF) : CNT_W'(1);
        irq_rx = (count >= thresh);
        irq_sc = half && sc_en && (|win_flag);
    end
endmodule

// File: rtl/rx_thresh_fifo.sv
module rx_thresh_fifo
    import rxf_pkg::*;
#(
    parameter  int DATA_W = 8,
    parameter  int DEPTH  = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_flag,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag,
    input  logic              err_clr,
    output logic [CNT_W-1:0]  fill_level,
    output logic              char_avail,
    output logic              irq_rx_avail,
    output logic              irq_special,
    output logic              overrun
);
    localparam int HALF = DEPTH / 2;

    rxf_ctl_t ctl_d, ctl_q;
    logic [HALF-1:0] win_flag;
    logic drop;

    rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .HALF(HALF), .CNT_W(CNT_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (wr_en),
        .push_data (wr_data),
        .push_flag (wr_flag),
        .pop_req   (rd_en),
        .pop_data  (rd_data),
        .pop_flag  (rd_flag),
        .count     (fill_level),
        .win_flag  (win_flag),
        .drop      (drop)
    );

    rxf_irq #(.HALF(HALF), .CNT_W(CNT_W)) irq_i (
        .count    (fill_level),
        .win_flag (win_flag),
        .half     (ctl_q.half),
        .sc_en    (ctl_q.sc_en),
        .irq_rx   (irq_rx_avail),
        .irq_sc   (irq_special)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (cfg_we) begin
            ctl_d.half  = cfg_wdata[CFG_HALF_BIT];
            ctl_d.sc_en = cfg_wdata[CFG_SC_BIT];
        end
        if (drop)         ctl_d.ovr = 1'b1;
        else if (err_clr) ctl_d.ovr = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign char_avail = (fill_level != '0);
    assign overrun    = ctl_q.ovr;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              err_clr,
    input logic              half,
    input logic              sc_en,
    input logic [CNT_W-1:0]  fill,
    input logic              irq_rx,
    input logic              irq_sc,
    input logic              ovr,
    input logic [DATA_W-1:0] rd_data
);
    localparam int HALF = DEPTH / 2;

    // R2
    lvl1_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!half && fill != '0) |-> irq_rx);
    // R3
    lvl4_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half && fill < CNT_W'(HALF)) |-> !irq_rx);
    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));
    // R5
    sc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(half && sc_en) |-> !irq_sc);
    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CNT_W'(DEPTH) && wr_en && !rd_en) |=> (ovr && fill == CNT_W'(DEPTH)));
    // R7
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(fill == CNT_W'(DEPTH) && wr_en && !rd_en)) |=> !ovr);
    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0 && rd_en) |=> $stable(rd_data));
    // R9
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && fill != '0) |=> $stable(fill));
endmodule

bind rx_thresh_fifo rxf_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .err_clr (err_clr),
    .half    (ctl_q.half),
    .sc_en   (ctl_q.sc_en),
    .fill    (fill_level),
    .irq_rx  (irq_rx_avail),
    .irq_sc  (irq_special),
    .ovr     (overrun),
    .rd_data (rd_data)
);

// File: tb/rx_thresh_fifo_tb_top.sv
module rx_thresh_fifo_tb_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n, cfg_we, wr_en, wr_flag, rd_en, err_clr;
    logic [7:0] cfg_wdata, wr_data, rd_data;
    logic       rd_flag, char_avail, irq_rx_avail, irq_special, overrun;
    logic [3:0] fill_level;

    int n_chk = 0, n_fail = 0;

    logic [8:0] q[$];
    bit  m_half, m_sc, m_ovr;
    logic [7:0] m_rdat;
    bit  m_rflg;

    always #(CLK_P/2) clk = ~clk;

    rx_thresh_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .wr_en(wr_en), .wr_data(wr_data), .wr_flag(wr_flag), .rd_en(rd_en),
        .rd_data(rd_data), .rd_flag(rd_flag), .err_clr(err_clr),
        .fill_level(fill_level), .char_avail(char_avail),
        .irq_rx_avail(irq_rx_avail), .irq_special(irq_special), .overrun(overrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_sc();
        int lim = (q.size() < 4) ? q.size() : 4;
        if (!(m_half && m_sc)) return 0;
        for (int i = 0; i < lim; i++) if (q[i][8]) return 1;
        return 0;
    endfunction

    task automatic compare(input bit w, input bit r, input bit was_empty);
        chk((w && r) ? "R9" : "R4", fill_level, q.size());
        chk("R6", char_avail, q.size() != 0);
        chk(m_half ? "R3" : "R2", irq_rx_avail, q.size() >= (m_half ? 4 : 1));
        chk("R5", irq_special, exp_sc());
        chk("R7", overrun, m_ovr);
        chk((r && was_empty) ? "R8" : "R4", rd_data, m_rdat);
        chk((r && was_empty) ? "R8" : "R4", rd_flag, m_rflg);
    endtask

    task automatic step(input bit w, input logic [7:0] d, input bit f, input bit r,
                        input bit cw, input logic [7:0] cd, input bit clr);
        bit was_empty, pop, push;
        wr_en = w; wr_data = d; wr_flag = f; rd_en = r;
        cfg_we = cw; cfg_wdata = cd; err_clr = clr;
        @(posedge clk);
        was_empty = (q.size() == 0);
        pop  = r && !was_empty;
        push = w && (q.size() < 8 || pop);
        if (pop) begin
            m_rdat = q[0][7:0]; m_rflg = q[0][8];
            void'(q.pop_front());
        end
        if (push) q.push_back({f, d});
        if (w && !push) m_ovr = 1;
        else if (clr)   m_ovr = 0;
        if (cw) begin m_half = cd[3]; m_sc = cd[0]; end
        @(negedge clk);
        compare(w, r, was_empty);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 0; cfg_we = 0; cfg_wdata = 0; wr_en = 0; wr_data = 0;
        wr_flag = 0; rd_en = 0; err_clr = 0;
        m_half = 0; m_sc = 0; m_ovr = 0; m_rdat = 0; m_rflg = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", fill_level, 0);
        chk("R1", irq_rx_avail | irq_special | char_avail | overrun, 0);
        chk("R1", rd_data, 0);
        // R8 empty read after reset
        step(0, 0, 0, 1, 0, 0, 0);
        // R2 one byte fires in default mode
        step(1, 8'h11, 0, 0, 0, 0, 0);
        // R10 unused bits set, threshold stays one byte
        step(0, 0, 0, 0, 1, 8'hF6, 0);
        chk("R10", irq_rx_avail, 1);
        // R3 half-full mode plus special enable
        step(0, 0, 0, 0, 1, 8'h09, 0);
        chk("R3", irq_rx_avail, 0);
        step(1, 8'h22, 0, 0, 0, 0, 0);
        step(1, 8'h33, 0, 0, 0, 0, 0);
        chk("R3", irq_rx_avail, 0);
        step(1, 8'h44, 0, 0, 0, 0, 0);
        chk("R3", irq_rx_avail, 1);
        // R5 flagged byte beyond oldest four, then moves in
        step(1, 8'h55, 1, 0, 0, 0, 0);
        chk("R5", irq_special, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        chk("R5", irq_special, 1);
        // fill to full, then overflow (R7)
        for (int i = 0; i < 5; i++) step(1, 8'h60 + 8'(i), 0, 0, 0, 0, 0);
        chk("R7", overrun, 1);
        // R9 simultaneous on full
        step(1, 8'h77, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1);
        chk("R7", overrun, 0);
        // drain, R5 clears after flagged read
        for (int i = 0; i < 9; i++) step(0, 0, 0, 1, 0, 0, 0);
        chk("R8", fill_level, 0);
        // R9 simultaneous on empty: write accepted, read ignored
        step(1, 8'h88, 1, 1, 0, 0, 0);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] cd = 8'($urandom);
            step(($urandom % 3) != 0, 8'($urandom), ($urandom % 5) == 0,
                 ($urandom % 2) == 0, ($urandom % 40) == 0, cd, ($urandom % 25) == 0);
        end
        summary();
        $finish;
    end
endmodule